// File: doc/BRIEF.md
# Multichannel Period Scanner with Shared Timebase

This block measures the period of many square-wave inputs at once without a counter per input. One free-running counter serves as a common timebase. Each input channel owns a capture register that takes a snapshot of the counter on every rising edge of that input. A flag marks the snapshot as fresh. A scanner steps through the channels, one per clock. When it finds a fresh snapshot, it subtracts that channel's previous snapshot, which is held in a small memory, to form the period in clock ticks. It then writes the new snapshot back to the memory and emits the period together with the channel index.

The inputs stand for a subset of a larger set of vibrating strings, taken one group at a time. A group address output tells the external drive circuitry which group is active. A one-cycle advance request moves to the next group and wraps after the last one. On an advance, all history is dropped, so the first edge of each channel in the new group only primes the memory. Averaging and comparison against a target period are left to logic downstream.

Top module: `period_scanner`

## Requirements
- R1: During and straight after reset, `per_valid` is 0 and `group_addr` is 0, and no channel has a stored previous snapshot.
- R2: The shared timebase advances by exactly one every clock and wraps modulo 2^CW.
- R3: A rising edge on `sig_in[i]` captures the timebase once, however long the input stays high. The reported period equals the number of clocks between two consecutive rising edges of that channel, provided those edges are at least N_CH+8 clocks apart.
- R4: The period is computed modulo 2^CW, so a period shorter than 2^CW clocks is exact even when the timebase wraps between the two edges.
- R5: The first rising edge of a channel after reset or after a group advance produces no output; it only stores the snapshot.
- R6: A result is one cycle with `per_valid` = 1. In that cycle, `per_chan` is the bit index i of the input that produced it, always below N_CH, and `per_value` carries the period.
- R7: The scanner visits channel indices 0 to N_CH-1 in a circle, one per clock. Every fresh snapshot is reported exactly once, within N_CH+4 clocks of its edge. Channels with no new edge report nothing.
- R8: A pulse on `group_advance` increments `group_addr`, which wraps from NGRP-1 to 0, with NGRP = ceil(N_STRINGS/N_CH). Without a pulse, `group_addr` holds.
- R9: A group advance discards all fresh snapshots and all previous snapshots. No result is issued in the cycle after the advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | N_CH | Square-wave inputs, one per channel |
| group_advance | input | 1 | One-cycle request to move to the next group |
| group_addr | output | clog2(NGRP) | Index of the group to be sustained |
| per_valid | output | 1 | Period result present this cycle |
| per_chan | output | clog2(N_CH) | Channel index of the result |
| per_value | output | CW | Period in timebase ticks |

## Verification
All inputs but one run at the same time, with staggered periods that differ between channels and between group phases. This shows whether results are tagged with the right channel and whether every edge is reported exactly once, even when many snapshots are waiting together. One channel stays idle, which exposes any result issued without an edge. One channel runs a period close to 2^CW on a narrowed timebase, so many snapshot pairs fall across a wrap and separate a modular subtraction from a plain one. A burst on every channel, placed just before a group advance, shows whether stale snapshots carry over into the new group.

// File: rtl/period_scanner.sv
module period_scanner #(
  parameter int N_CH = 44,
  parameter int CW = 21,
  parameter int N_STRINGS = 219,
  localparam int NGRP = (N_STRINGS + N_CH - 1) / N_CH,
  localparam int IW = $clog2(N_CH),
  localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] sig_in,
  input  logic            group_advance,
  output logic [GW-1:0]   group_addr,
  output logic            per_valid,
  output logic [IW-1:0]   per_chan,
  output logic [CW-1:0]   per_value
);

  logic [CW-1:0]   tb_cnt;
  logic [N_CH-1:0] s1, s2, s3, pend, seen;
  logic [CW-1:0]   cap  [N_CH];
  logic [CW-1:0]   prev [N_CH];
  logic [IW-1:0]   scan;

  wire [N_CH-1:0] rise = s2 & ~s3;
  wire            take = pend[scan] && !group_advance;

  always_ff @(posedge clk)
    if (!rst_n) tb_cnt <= '0;
    else        tb_cnt <= tb_cnt + 1'b1;

  always_ff @(posedge clk)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= sig_in; s2 <= s1; s3 <= s2;
    end

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    always_ff @(posedge clk)
      if (!rst_n)       cap[i] <= '0;
      else if (rise[i]) cap[i] <= tb_cnt;

    always_ff @(posedge clk)
      if (!rst_n || group_advance)          pend[i] <= 1'b0;
      else if (rise[i])                     pend[i] <= 1'b1;
      else if (take && scan == IW'(i))      pend[i] <= 1'b0;
  end

  always_ff @(posedge clk)
    if (!rst_n)                     scan <= '0;
    else if (scan == IW'(N_CH - 1)) scan <= '0;
    else                            scan <= scan + 1'b1;

  always_ff @(posedge clk)
    if (take) prev[scan] <= cap[scan];

  always_ff @(posedge clk)
    if (!rst_n || group_advance) seen <= '0;
    else if (take)               seen[scan] <= 1'b1;

  always_ff @(posedge clk)
    if (!rst_n) begin
      per_valid <= 1'b0;
      per_chan  <= '0;
      per_value <= '0;
    end else begin
      per_valid <= take && seen[scan];
      per_chan  <= scan;
      per_value <= cap[scan] - prev[scan];
    end

  always_ff @(posedge clk)
    if (!rst_n)                               group_addr <= '0;
    else if (group_advance)
      group_addr <= (group_addr == GW'(NGRP - 1)) ? '0 : group_addr + 1'b1;

endmodule

// File: rtl/period_scanner_chk.sv
module period_scanner_chk #(
  parameter int N_CH = 44,
  parameter int CW = 21,
  parameter int NGRP = 5,
  parameter int IW = 6,
  parameter int GW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          group_advance,
  input logic [GW-1:0] group_addr,
  input logic          per_valid,
  input logic [IW-1:0] per_chan,
  input logic [CW-1:0] tb_cnt
);

  always @(posedge clk)
    if (!rst_n) p_reset_quiet_r1: assert (!per_valid);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tb_cnt == CW'($past(tb_cnt) + 1'b1));

  p_chan_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    per_valid |-> per_chan <= IW'(N_CH - 1));

  p_grp_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    group_advance && group_addr == GW'(NGRP - 1) |=> group_addr == '0);

  p_grp_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    group_advance && group_addr != GW'(NGRP - 1) |=> group_addr == GW'($past(group_addr) + 1'b1));

  p_grp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !group_advance |=> $stable(group_addr));

  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    group_advance |=> !per_valid);

endmodule

bind period_scanner period_scanner_chk #(
  .N_CH(N_CH), .CW(CW), .NGRP(NGRP), .IW(IW), .GW(GW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .group_advance(group_advance),
  .group_addr(group_addr), .per_valid(per_valid), .per_chan(per_chan),
  .tb_cnt(tb_cnt)
);

// File: tb/period_scanner_test.sv
module period_scanner_test;
  localparam int N = 44, CW = 12, NS = 219, NG = 5, IW = 6, GW = 3;

  logic clk = 0, rst_n = 0, group_advance = 0;
  logic [N-1:0] sig_in = '0;
  logic per_valid;
  logic [IW-1:0] per_chan;
  logic [CW-1:0] per_value;
  logic [GW-1:0] group_addr;

  period_scanner #(.N_CH(N), .CW(CW), .N_STRINGS(NS)) uut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .group_advance(group_advance),
    .group_addr(group_addr), .per_valid(per_valid), .per_chan(per_chan),
    .per_value(per_value)
  );

  always #2 clk = ~clk;

  int vec = 0, bad = 0, cyc = 0, g = 0;
  logic [CW-1:0] expq [N][$];
  logic [CW-1:0] e;
  int nxt[N], per[N], hi[N], lastr[N];
  bit seen_b[N];
  bit active = 0, burst_req = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic advance();
    @(negedge clk) group_advance = 1;
    @(negedge clk) group_advance = 0;
    g = (g + 1) % NG;
    for (int c = 0; c < N; c++) seen_b[c] = 0;
    chk(group_addr == GW'(g), "R8 group address after advance", group_addr, g);
  endtask

  // driver: schedules rising edges and pushes expected periods
  always @(negedge clk) if (rst_n) begin
    cyc++;
    for (int c = 0; c < N; c++) begin
      if (hi[c] > 0) begin
        hi[c]--;
        if (hi[c] == 0) sig_in[c] = 1'b0;
      end
      if (burst_req) begin
        sig_in[c] = 1'b1; hi[c] = 5;
      end else if (active && per[c] != 0 && cyc == nxt[c]) begin
        sig_in[c] = 1'b1; hi[c] = 5;
        if (seen_b[c]) expq[c].push_back(CW'(cyc - lastr[c]));
        lastr[c] = cyc; seen_b[c] = 1; nxt[c] += per[c];
      end
    end
    burst_req = 0;
  end

  // monitor: pops expected periods per channel
  always @(negedge clk) if (rst_n && per_valid) begin
    if (per_chan >= N || expq[per_chan].size() == 0)
      chk(0, "R5/R6 result with no expected period on channel", per_chan, -1);
    else begin
      e = expq[per_chan].pop_front();
      chk(per_value == e, "R3/R4 period value", per_value, e);
    end
  end

  initial begin
    for (int c = 0; c < N; c++) begin hi[c] = 0; seen_b[c] = 0; end
    repeat (3) @(negedge clk);
    chk(per_valid == 0, "R1 valid low in reset", per_valid, 0);
    chk(group_addr == 0, "R1 group address in reset", group_addr, 0);
    rst_n = 1;
    @(negedge clk);
    chk(per_valid == 0, "R1 valid low after reset", per_valid, 0);
    for (int ph = 0; ph < 6; ph++) begin
      for (int c = 0; c < N; c++) begin
        if (c == 0) per[c] = 0;
        else if (c == N - 1) per[c] = 3900 + ph * 30;
        else per[c] = 60 + ((c * 37 + ph * 53) % 340);
        nxt[c] = cyc + 3 + c;
      end
      active = 1;
      repeat (8000) @(negedge clk);
      active = 0;
      repeat (150) @(negedge clk);
      for (int c = 0; c < N; c++)
        chk(expq[c].size() == 0, "R7 every fresh capture reported", expq[c].size(), 0);
      if (ph == 2) begin
        advance();
        repeat (20) @(negedge clk);
        burst_req = 1;
        repeat (6) @(negedge clk);
        advance();
        repeat (60) @(negedge clk);
      end else begin
        advance();
      end
    end
    repeat (150) @(negedge clk);
    for (int c = 0; c < N; c++)
      chk(expq[c].size() == 0, "R9 no leftover results", expq[c].size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule